// File: doc/BRIEF.md
# Delay-Line Collision-Free Cell Scheduler

This block is the electronic controller of a two-stage cell switch whose stages are joined by a bank of delay lines of unequal length. Delay line number d holds a cell for exactly d slots, for d from 1 to `NUM_LINES`. In every slot the block reads a valid bit and a destination port from each of `NUM_IN` arrival lanes. It parks each cell on a delay line chosen so that, when the cell emerges, its output port is free in that slot. The choice takes into account every cell still travelling on the lines. Cells for which no line qualifies are reported as dropped.

The block has two outputs. For the first stage it gives, per arrival lane, the number of the chosen delay line or a drop flag. For the second stage it gives, per output port, the number of the delay line whose cell leaves toward that port in the current slot. Internally it keeps a table of reservations indexed by future slot offset and output port, and this table moves one row closer every slot. A per-lane order mode can be switched on. In that mode, later cells from one lane never overtake earlier ones.

Top module: `cell_delay_scheduler`

## Requirements
- R1: While `rst_n` is low and in the first slot after it rises, every output is zero. Reset also discards all reservations, so no exit is reported later for a cell scheduled before reset.
- R2: Results appear one clock after the arrival is sampled. For each lane with `arrValid` high, exactly one of `selValid` and `dropFlag` is set. For a lane with `arrValid` low, both are low and its destination is ignored. A lane's field in `selLine` sits at bits [i*DLY_W +: DLY_W] and holds the delay d (1..NUM_LINES) of the chosen line, or 0 when the lane is not placed.
- R3: A cell shown placed on line d toward port o leads to `exitValid[o]` high with `exitLine` field o equal to d exactly d clocks after the placement is shown.
- R4: No two cells are ever scheduled to leave toward the same output port in the same slot, including cells scheduled in earlier slots.
- R5: Within one slot a delay line accepts at most one cell.
- R6: Lanes are served in ascending index order, and each lane takes the shortest line that satisfies all constraints.
- R7: A valid cell for which no line satisfies the constraints is dropped.
- R8: With `orderMode` high at arrival, a placed cell leaves strictly after the most recent cell previously placed from the same lane. If only lines that would violate this are free, the cell is dropped.
- R9: With `orderMode` low, the shortest qualifying line is taken even when the cell then leaves before an earlier cell of the same lane.
- R10: An output port with no exiting cell reports `exitValid` low and a zero `exitLine` field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cell slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| orderMode | input | 1 | Keep per-lane exit order when high |
| arrValid | input | NUM_IN | A cell arrives on lane i |
| arrDest | input | NUM_IN*PORT_W | Destination port per lane, lane i at [i*PORT_W +: PORT_W] |
| selValid | output | NUM_IN | Lane i was placed on a delay line |
| selLine | output | NUM_IN*DLY_W | Chosen delay per lane, 0 when not placed |
| dropFlag | output | NUM_IN | Lane i's cell was lost |
| exitValid | output | NUM_IN | A cell leaves toward port o this slot |
| exitLine | output | NUM_IN*DLY_W | Delay line feeding port o this slot, 0 if none |

## Verification
A corrupted reservation row shows up in two places. It can reach `exitValid`/`exitLine` as a missing, extra or mislabelled exit up to `NUM_LINES` slots later. It can also show up sooner, as a wrong line choice or a needless drop for the next arrival that consults that row. A stale per-lane order record shows at `selLine` on the lane's next arrival, which takes a line that is too short or is dropped. The bench predicts every exit from the line choices it expects, so a wrong row is caught in the slot where it surfaces.

// File: rtl/dlsched_pkg.sv
package dlsched_pkg;
  localparam int NUM_IN    = 4;
  localparam int NUM_LINES = 3;
  localparam int PORT_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int DLY_W     = $clog2(NUM_LINES + 1);

  typedef logic [PORT_W-1:0] port_t;
  typedef logic [DLY_W-1:0]  dly_t;

  // strobes from control to datapath, one per arrival lane
  typedef struct packed {
    logic  place;
    logic  drop;
    dly_t  dly;
    port_t dest;
  } cellCmd_t;

  // one reservation: output port busy in that future slot, fed by line
  typedef struct packed {
    logic busy;
    dly_t line;
  } resEntry_t;
endpackage

// File: rtl/dlsched_ctrl.sv
module dlsched_ctrl
  import dlsched_pkg::*;
(
  input  logic                          orderMode,
  input  logic [NUM_IN-1:0]             arrValid,
  input  logic [NUM_IN*PORT_W-1:0]      arrDest,
  input  logic [NUM_LINES:1][NUM_IN-1:0] outTaken,
  input  dly_t [NUM_IN-1:0]             lastExit,
  output cellCmd_t [NUM_IN-1:0]         cmd
);
  logic [NUM_LINES:1] lineUsed;
  port_t              dst;
  logic               found;
  dly_t               pick;

  // lanes in ascending order, lines from shortest upward
  always_comb begin
    lineUsed = '0;
    cmd      = '0;
    dst      = '0;
    found    = 1'b0;
    pick     = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      dst   = arrDest[i*PORT_W +: PORT_W];
      found = 1'b0;
      pick  = '0;
      for (int d = 1; d <= NUM_LINES; d++) begin
        if (arrValid[i] && !found && !lineUsed[d] && !outTaken[d][dst] &&
            (!orderMode || dly_t'(d) >= lastExit[i])) begin
          found       = 1'b1;
          pick        = dly_t'(d);
          lineUsed[d] = 1'b1;
        end
      end
      if (arrValid[i]) begin
        cmd[i].dest  = dst;
        cmd[i].place = found;
        cmd[i].drop  = !found;
        cmd[i].dly   = pick;
      end
    end
  end
endmodule

// File: rtl/dlsched_datapath.sv
module dlsched_datapath
  import dlsched_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  cellCmd_t [NUM_IN-1:0]          cmd,
  output logic [NUM_LINES:1][NUM_IN-1:0] outTaken,
  output dly_t [NUM_IN-1:0]              lastExit,
  output logic [NUM_IN-1:0]              selValid,
  output logic [NUM_IN*DLY_W-1:0]        selLine,
  output logic [NUM_IN-1:0]              dropFlag,
  output logic [NUM_IN-1:0]              exitValid,
  output logic [NUM_IN*DLY_W-1:0]        exitLine
);
  // row k: reservations for the slot k cycles from now; row 0 is exiting
  resEntry_t [NUM_LINES:0][NUM_IN-1:0] resTbl, resNxt;
  dly_t [NUM_IN-1:0]                   lastNxt;
  logic [NUM_IN-1:0]                   selValidNxt, dropNxt;
  logic [NUM_IN*DLY_W-1:0]             selLineNxt;

  always_comb begin
    resNxt = '0;
    for (int k = 0; k < NUM_LINES; k++) resNxt[k] = resTbl[k+1];
    for (int i = 0; i < NUM_IN; i++) begin
      if (cmd[i].place) begin
        resNxt[cmd[i].dly][cmd[i].dest].busy = 1'b1;
        resNxt[cmd[i].dly][cmd[i].dest].line = cmd[i].dly;
      end
    end
  end

  // remaining slots until the lane's latest scheduled exit
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      if (cmd[i].place)           lastNxt[i] = cmd[i].dly;
      else if (lastExit[i] != '0) lastNxt[i] = lastExit[i] - dly_t'(1);
      else                        lastNxt[i] = '0;
      selValidNxt[i]                    = cmd[i].place;
      dropNxt[i]                        = cmd[i].drop;
      selLineNxt[i*DLY_W +: DLY_W]      = cmd[i].dly;
    end
  end

  // a line of delay d lands in row d after the shift, so it checks row d+1 now
  for (genvar d = 1; d <= NUM_LINES; d++) begin : g_taken
    for (genvar o = 0; o < NUM_IN; o++) begin : g_port
      if (d < NUM_LINES) begin : g_row
        assign outTaken[d][o] = resTbl[d+1][o].busy;
      end else begin : g_edge
        assign outTaken[d][o] = 1'b0;
      end
    end
  end

  for (genvar o = 0; o < NUM_IN; o++) begin : g_exit
    assign exitValid[o]                 = resTbl[0][o].busy;
    assign exitLine[o*DLY_W +: DLY_W]   = resTbl[0][o].line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resTbl   <= '0;
      lastExit <= '0;
      selValid <= '0;
      selLine  <= '0;
      dropFlag <= '0;
    end else begin
      resTbl   <= resNxt;
      lastExit <= lastNxt;
      selValid <= selValidNxt;
      selLine  <= selLineNxt;
      dropFlag <= dropNxt;
    end
  end
endmodule

// File: rtl/cell_delay_scheduler.sv
module cell_delay_scheduler
  import dlsched_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      orderMode,
  input  logic [NUM_IN-1:0]         arrValid,
  input  logic [NUM_IN*PORT_W-1:0]  arrDest,
  output logic [NUM_IN-1:0]         selValid,
  output logic [NUM_IN*DLY_W-1:0]   selLine,
  output logic [NUM_IN-1:0]         dropFlag,
  output logic [NUM_IN-1:0]         exitValid,
  output logic [NUM_IN*DLY_W-1:0]   exitLine
);
  cellCmd_t [NUM_IN-1:0]          cmd;
  logic [NUM_LINES:1][NUM_IN-1:0] outTaken;
  dly_t [NUM_IN-1:0]              lastExit;

  dlsched_ctrl u_ctrl (
    .orderMode (orderMode),
    .arrValid  (arrValid),
    .arrDest   (arrDest),
    .outTaken  (outTaken),
    .lastExit  (lastExit),
    .cmd       (cmd)
  );

  dlsched_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .outTaken  (outTaken),
    .lastExit  (lastExit),
    .selValid  (selValid),
    .selLine   (selLine),
    .dropFlag  (dropFlag),
    .exitValid (exitValid),
    .exitLine  (exitLine)
  );
endmodule

// File: rtl/cell_delay_scheduler_chk.sv
module cell_delay_scheduler_chk
  import dlsched_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      orderMode,
  input logic [NUM_IN-1:0]         arrValid,
  input logic [NUM_IN*PORT_W-1:0]  arrDest,
  input logic [NUM_IN-1:0]         selValid,
  input logic [NUM_IN*DLY_W-1:0]   selLine,
  input logic [NUM_IN-1:0]         dropFlag,
  input logic [NUM_IN-1:0]         exitValid,
  input logic [NUM_IN*DLY_W-1:0]   exitLine
);
  localparam int CW = $clog2(NUM_IN + 2) + 1;

  port_t [NUM_IN-1:0]                          destQ;
  logic [NUM_LINES:0][NUM_IN-1:0][CW-1:0]      predCnt, cntNxt;
  dly_t [NUM_LINES:0][NUM_IN-1:0]              predLine, lineNxt;
  dly_t [NUM_IN-1:0]                           lastRem;
  logic [NUM_LINES:1][NUM_IN-1:0]              useMap;

  // independent exit prediction from the shown placements
  always_comb begin
    cntNxt  = '0;
    lineNxt = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      cntNxt[k]  = predCnt[k+1];
      lineNxt[k] = predLine[k+1];
    end
    for (int i = 0; i < NUM_IN; i++) begin
      if (selValid[i] && selLine[i*DLY_W +: DLY_W] != '0 &&
          int'(selLine[i*DLY_W +: DLY_W]) <= NUM_LINES) begin
        cntNxt[int'(selLine[i*DLY_W +: DLY_W]) - 1][destQ[i]] =
          cntNxt[int'(selLine[i*DLY_W +: DLY_W]) - 1][destQ[i]] + CW'(1);
        lineNxt[int'(selLine[i*DLY_W +: DLY_W]) - 1][destQ[i]] =
          selLine[i*DLY_W +: DLY_W];
      end
    end
  end

  always_comb begin
    for (int d = 1; d <= NUM_LINES; d++)
      for (int i = 0; i < NUM_IN; i++)
        useMap[d][i] = selValid[i] && (int'(selLine[i*DLY_W +: DLY_W]) == d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      destQ    <= '0;
      predCnt  <= '0;
      predLine <= '0;
      lastRem  <= '0;
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        destQ[i] <= arrDest[i*PORT_W +: PORT_W];
        if (selValid[i])           lastRem[i] <= selLine[i*DLY_W +: DLY_W];
        else if (lastRem[i] != '0) lastRem[i] <= lastRem[i] - dly_t'(1);
      end
      predCnt  <= cntNxt;
      predLine <= lineNxt;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (selValid == '0 && dropFlag == '0 && exitValid == '0));

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((selValid | dropFlag) == $past(arrValid)) &&
                      ((selValid & dropFlag) == '0)));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    a_r2_line_range: assert property (@(posedge clk) disable iff (!rst_n)
      selValid[i] |-> (selLine[i*DLY_W +: DLY_W] != '0 &&
                       int'(selLine[i*DLY_W +: DLY_W]) <= NUM_LINES));
    a_r8_keep_order: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(orderMode) && selValid[i]) |->
        (selLine[i*DLY_W +: DLY_W] >= lastRem[i]));
  end

  for (genvar d = 1; d <= NUM_LINES; d++) begin : g_line
    a_r5_line_once: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(useMap[d]));
  end

  for (genvar o = 0; o < NUM_IN; o++) begin : g_port
    a_r3_exit_seen: assert property (@(posedge clk) disable iff (!rst_n)
      exitValid[o] == (predCnt[0][o] != '0));
    a_r3_exit_line: assert property (@(posedge clk) disable iff (!rst_n)
      exitValid[o] |-> (exitLine[o*DLY_W +: DLY_W] == predLine[0][o]));
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !exitValid[o] |-> (exitLine[o*DLY_W +: DLY_W] == '0));
    for (genvar k = 0; k <= NUM_LINES; k++) begin : g_off
      a_r4_single_exit: assert property (@(posedge clk) disable iff (!rst_n)
        predCnt[k][o] <= CW'(1));
    end
  end
endmodule

bind cell_delay_scheduler cell_delay_scheduler_chk u_chk (.*);

// File: tb/cell_delay_scheduler_test.sv
`timescale 1ns/1ps
module cell_delay_scheduler_test;
  import dlsched_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic orderMode = 1'b0;
  logic [3:0] arrValid = '0;
  logic [7:0] arrDest = '0;
  logic [3:0] selValid, dropFlag, exitValid;
  logic [7:0] selLine, exitLine;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cell_delay_scheduler uut (
    .clk(clk), .rst_n(rst_n), .orderMode(orderMode),
    .arrValid(arrValid), .arrDest(arrDest),
    .selValid(selValid), .selLine(selLine), .dropFlag(dropFlag),
    .exitValid(exitValid), .exitLine(exitLine)
  );

  // {mode, valid[3:0], dest lane3..lane0, expected line lane3..lane0 (0 = none)}
  localparam int NROWS = 28;
  localparam logic [20:0] VEC [NROWS] = '{
    {1'b0, 4'b1111, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b0, 4'b0011, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd3},
    {1'b0, 4'b1100, 2'd0, 2'd1, 2'd0, 2'd0, 2'd3, 2'd1, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b1110, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd0},
    {1'b0, 4'b1111, 2'd2, 2'd3, 2'd2, 2'd3, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b1, 4'b0111, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b1, 4'b0100, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd3, 2'd0, 2'd0},
    {1'b1, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b1, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b1, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b1, 4'b0111, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b1, 4'b0110, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0111, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b0, 4'b0110, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd3, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b1111, 2'd3, 2'd2, 2'd1, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
    {1'b0, 4'b0000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0}
  };

  logic [3:0] expExV [64];
  logic [7:0] expExL [64];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int s = 0; s < 64; s++) begin expExV[s] = '0; expExL[s] = '0; end

    // R1: outputs quiet while held in reset
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {selValid, selLine, dropFlag, exitValid, exitLine}, '0);
    rst_n = 1'b1;

    // R2: invalid lanes with nonzero destinations are ignored
    for (int s = 0; s < 4; s++) begin
      arrValid = '0;
      arrDest  = 8'hFF;
      @(negedge clk);
      check("R2 R10 invalid lanes ignored",
            {selValid, selLine, dropFlag, exitValid, exitLine}, '0);
    end

    // main table: R2 R4 R5 R6 R7 R8 R9 on selections, R3 R4 R10 on exits
    for (int r = 0; r < NROWS; r++) begin
      logic [3:0] expSel, expDrop;
      logic [7:0] expLine;
      orderMode = VEC[r][20];
      arrValid  = VEC[r][19:16];
      arrDest   = VEC[r][15:8];
      expSel = '0; expDrop = '0; expLine = '0;
      for (int i = 0; i < 4; i++) begin
        logic [1:0] e, dst;
        e   = VEC[r][2*i +: 2];
        dst = VEC[r][8 + 2*i +: 2];
        if (VEC[r][16+i]) begin
          if (e != 2'd0) begin
            expSel[i] = 1'b1;
            expLine[2*i +: 2] = e;
            expExV[r + int'(e)][dst] = 1'b1;
            expExL[r + int'(e)][2*dst +: 2] = e;
          end else begin
            expDrop[i] = 1'b1;
          end
        end
      end
      @(negedge clk);
      check($sformatf("R2 R5 R6 R7 R8 R9 selection row %0d", r),
            {selValid, selLine, dropFlag}, {expSel, expLine, expDrop});
      check($sformatf("R3 R4 R10 exits slot %0d", r),
            {exitValid, exitLine}, {expExV[r], expExL[r]});
    end

    // R1: reset in mid-flight discards pending reservations
    orderMode = 1'b0;
    arrValid  = 4'b1111;
    arrDest   = 8'h00;
    @(negedge clk);
    check("R7 full slot before reset", {selValid, selLine, dropFlag},
          {4'b0111, 8'b00_11_10_01, 4'b1000});
    arrValid = '0;
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {selValid, selLine, dropFlag, exitValid, exitLine}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      check("R1 no exits after reset", {exitValid, exitLine, selValid, dropFlag}, '0);
    end

    finishRun();
  end
endmodule